// File: doc/BRIEF.md
# External Bus Cycle Phase Sequencer

This block times a single access on an external memory bus for one of several chip-select regions. A request carries a direction flag and a region index. Once it is accepted, the sequencer walks through six phases in a fixed order: address setup, address latch, delay, turnaround, command and hold. The region's own timing word sets the length of each phase. The command phase can also stretch until a READY pin reports that the device has finished.

Each region has a function word. It enables the region, turns READY waiting on or off, chooses between a direct READY sample and a two-stage synchronized one, and selects a multiplexed bus, where the address is driven on the data lines early in the cycle. A phase whose length is zero is skipped without costing a cycle. A single-cycle done pulse closes every accepted request. Address decoding, bus arbitration and the data path are outside this block.

Top module: `xps_top`

## Requirements
- R1: After reset every output is low: `cs_o`, `ale_o`, `rd_o`, `wr_o`, `addr_drv_o` and `done_o`.
- R2: A request is accepted on a clock edge where `req_valid_i` is high and the sequencer is idle. From the next cycle, the region's bit of `cs_o` (bit n for region n) is high for exactly A+B+C+D+E+F consecutive cycles. The phase lengths come from the timing word: E = bits[4:0]+1, A = bits[6:5], B = bit[7]+1, C = bits[9:8], D = bit[10]. At most one `cs_o` bit is ever high.
- R3: `ale_o` is high for exactly the B cycles of the access and never together with a command strobe.
- R4: During the command phase, `rd_o` is high for a read (`req_write_i`=0) and `wr_o` is high for a write, never both. With waiting disabled (function bit[1]=0) the strobe lasts exactly E cycles.
- R5: The hold phase F lasts timing bits[12:11] cycles for a read and bits[14:13] cycles for a write.
- R6: With function bit[3]=1 (multiplexed bus), `addr_drv_o` is high for exactly the A+B cycles of phases A and B. With bit[3]=0 it stays low.
- R7: With function bit[1]=1, the command phase ends at the first edge where its minimum E cycles have elapsed and READY is asserted. READY is asserted when `ready_pin_i` equals `ready_pol_i` (1 = active high, 0 = active low).
- R8: With function bit[2]=1 (synchronous READY), the pin is used at the edge that samples it. With bit[2]=0 it passes through two flops, so a READY that rises later than the minimum length ends the command phase two cycles later than in synchronous mode.
- R9: A request to a region whose function bit[0]=0 asserts no `cs_o` bit and no strobe, and `done_o` pulses in the first cycle after acceptance.
- R10: `done_o` is a one-cycle pulse in the cycle after the last chip-select cycle. Requests presented while an access is in progress are ignored.
- R11: A phase of length zero (A, C, D or F) takes no cycle. With all of them zero, the access lasts B+E cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_region_i | input | RW | Region index of the request |
| timing_cfg_i | input | NREG*15 | Timing words, region n at bits [15n+14:15n] |
| func_cfg_i | input | NREG*4 | Function words, region n at bits [4n+3:4n] |
| ready_pol_i | input | 1 | READY polarity, 1 = active high |
| ready_pin_i | input | 1 | READY pin |
| ale_o | output | 1 | Address latch enable |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| cs_o | output | NREG | Chip selects, active high |
| addr_drv_o | output | 1 | Address is driven on the multiplexed data lines |
| done_o | output | 1 | Access finished |

## Verification
A phase counter that is off by one shows up directly as a chip-select, ALE or strobe window that is one cycle too long or too short. It is visible at the ports in the same access, no later than the done pulse. A wrong next-phase choice, such as a zero-length phase not being skipped or the read and write hold lengths being swapped, changes the per-access cycle counts that the bench compares when `done_o` rises. A READY path with the wrong number of flops or the wrong polarity moves the end of the command phase by whole cycles, which the comparison of synchronous and asynchronous runs exposes within one access.

// File: rtl/xps_pkg.sv
package xps_pkg;
  localparam int TW = 15;  // timing word width
  localparam int FW = 4;   // function word width
  localparam int CW = 6;   // phase counter width (max 32 cycles)

  typedef enum logic [2:0] {
    PH_IDLE, PH_A, PH_B, PH_C, PH_D, PH_E, PH_F, PH_END
  } phase_e;

  // function word fields
  function automatic logic fn_enable(logic [FW-1:0] f); return f[0]; endfunction
  function automatic logic fn_wait(logic [FW-1:0] f);   return f[1]; endfunction
  function automatic logic fn_sync(logic [FW-1:0] f);   return f[2]; endfunction
  function automatic logic fn_mux(logic [FW-1:0] f);    return f[3]; endfunction

  // cycles spent in phase p for timing word t and direction wr
  function automatic logic [CW-1:0] phase_len(phase_e p, logic [TW-1:0] t, logic wr);
    case (p)
      PH_A:    return {4'd0, t[6:5]};
      PH_B:    return {5'd0, t[7]} + 6'd1;
      PH_C:    return {4'd0, t[9:8]};
      PH_D:    return {5'd0, t[10]};
      PH_E:    return {1'b0, t[4:0]} + 6'd1;
      PH_F:    return wr ? {4'd0, t[14:13]} : {4'd0, t[12:11]};
      default: return 6'd1;
    endcase
  endfunction

  function automatic phase_e phase_succ(phase_e p);
    case (p)
      PH_IDLE: return PH_A;
      PH_A:    return PH_B;
      PH_B:    return PH_C;
      PH_C:    return PH_D;
      PH_D:    return PH_E;
      PH_E:    return PH_F;
      PH_F:    return PH_END;
      default: return PH_IDLE;
    endcase
  endfunction

  // next phase after p, skipping every zero-length phase
  function automatic phase_e phase_advance(phase_e p, logic [TW-1:0] t, logic wr);
    phase_e n;
    n = phase_succ(p);
    for (int i = 0; i < 5; i++)
      if (n != PH_END && n != PH_IDLE && phase_len(n, t, wr) == '0)
        n = phase_succ(n);
    return n;
  endfunction
endpackage

// File: rtl/xps_ready_cond.sv
module xps_ready_cond #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic pol_i,
  input  logic sync_mode_i,
  output logic ready_o
);
  localparam int TOP = STAGES - 1;

  logic             asserted;
  logic [TOP:0]     sh;

  assign asserted = pol_i ? pin_i : ~pin_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[TOP-1:0], asserted};
  end

  assign ready_o = sync_mode_i ? asserted : sh[TOP];
endmodule

// File: rtl/xps_cfg_select.sv
module xps_cfg_select
  import xps_pkg::*;
#(
  parameter int NREG = 4,
  localparam int RW = $clog2(NREG)
) (
  input  logic [NREG*TW-1:0] timing_flat_i,
  input  logic [NREG*FW-1:0] func_flat_i,
  input  logic [RW-1:0]      region_i,
  output logic [TW-1:0]      tw_o,
  output logic [FW-1:0]      fw_o
);
  logic [TW-1:0] tw_arr [NREG];
  logic [FW-1:0] fw_arr [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign tw_arr[g] = timing_flat_i[g*TW +: TW];
    assign fw_arr[g] = func_flat_i[g*FW +: FW];
  end

  assign tw_o = tw_arr[region_i];
  assign fw_o = fw_arr[region_i];
endmodule

// File: rtl/xps_phase_ctrl.sv
module xps_phase_ctrl
  import xps_pkg::*;
#(
  parameter int NREG = 4,
  localparam int RW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [RW-1:0] req_region_i,
  input  logic [TW-1:0] sel_tw_i,
  input  logic [FW-1:0] sel_fw_i,
  input  logic          ready_ok_i,
  output phase_e        phase_o,
  output logic          snap_write_o,
  output logic [RW-1:0] snap_region_o,
  output logic [FW-1:0] snap_fw_o,
  output logic          accept_o,
  output logic          leave_o
);
  phase_e        state, first_ph, next_ph;
  logic [CW-1:0] cnt;
  logic [TW-1:0] snap_tw;
  logic          in_access, wait_ok;

  assign in_access = state inside {PH_A, PH_B, PH_C, PH_D, PH_E, PH_F};
  assign accept_o  = (state == PH_IDLE) && req_valid_i;
  assign wait_ok   = (state != PH_E) || !fn_wait(snap_fw_o) || ready_ok_i;
  assign leave_o   = in_access && (cnt == '0) && wait_ok;
  assign first_ph  = fn_enable(sel_fw_i) ? phase_advance(PH_IDLE, sel_tw_i, req_write_i) : PH_END;
  assign next_ph   = phase_advance(state, snap_tw, snap_write_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= PH_IDLE;
      cnt           <= '0;
      snap_tw       <= '0;
      snap_fw_o     <= '0;
      snap_write_o  <= 1'b0;
      snap_region_o <= '0;
    end else if (accept_o) begin
      state         <= first_ph;
      cnt           <= phase_len(first_ph, sel_tw_i, req_write_i) - 6'd1;
      snap_tw       <= sel_tw_i;
      snap_fw_o     <= sel_fw_i;
      snap_write_o  <= req_write_i;
      snap_region_o <= req_region_i;
    end else if (leave_o) begin
      state <= next_ph;
      cnt   <= phase_len(next_ph, snap_tw, snap_write_o) - 6'd1;
    end else if (state == PH_END) begin
      state <= PH_IDLE;
    end else if (in_access && cnt != '0) begin
      cnt <= cnt - 6'd1;
    end
  end

  assign phase_o = state;
endmodule

// File: rtl/xps_top.sv
module xps_top
  import xps_pkg::*;
#(
  parameter int NREG = 4,
  localparam int RW = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic [RW-1:0]      req_region_i,
  input  logic [NREG*TW-1:0] timing_cfg_i,
  input  logic [NREG*FW-1:0] func_cfg_i,
  input  logic               ready_pol_i,
  input  logic               ready_pin_i,
  output logic               ale_o,
  output logic               rd_o,
  output logic               wr_o,
  output logic [NREG-1:0]    cs_o,
  output logic               addr_drv_o,
  output logic               done_o
);
  logic [TW-1:0] sel_tw;
  logic [FW-1:0] sel_fw, snap_fw;
  logic [RW-1:0] snap_region;
  logic          snap_write, ready_ok, accept, leave, snap_en, in_access;
  logic [NREG-1:0] region_hot;
  phase_e        phase;

  xps_cfg_select #(.NREG(NREG)) u_sel (
    .timing_flat_i(timing_cfg_i), .func_flat_i(func_cfg_i),
    .region_i(req_region_i), .tw_o(sel_tw), .fw_o(sel_fw)
  );

  xps_ready_cond #(.STAGES(2)) u_rdy (
    .clk(clk), .rst_n(rst_n), .pin_i(ready_pin_i), .pol_i(ready_pol_i),
    .sync_mode_i(fn_sync(snap_fw)), .ready_o(ready_ok)
  );

  xps_phase_ctrl #(.NREG(NREG)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i),
    .req_write_i(req_write_i), .req_region_i(req_region_i),
    .sel_tw_i(sel_tw), .sel_fw_i(sel_fw), .ready_ok_i(ready_ok),
    .phase_o(phase), .snap_write_o(snap_write), .snap_region_o(snap_region),
    .snap_fw_o(snap_fw), .accept_o(accept), .leave_o(leave)
  );

  assign snap_en   = fn_enable(snap_fw);
  assign in_access = phase inside {PH_A, PH_B, PH_C, PH_D, PH_E, PH_F};

  always_comb begin
    region_hot = '0;
    region_hot[snap_region] = 1'b1;
  end

  assign cs_o       = (in_access && snap_en) ? region_hot : '0;
  assign ale_o      = (phase == PH_B);
  assign rd_o       = (phase == PH_E) && !snap_write;
  assign wr_o       = (phase == PH_E) && snap_write;
  assign addr_drv_o = (phase == PH_A || phase == PH_B) && fn_mux(snap_fw);
  assign done_o     = (phase == PH_END);
endmodule

// File: rtl/xps_checker.sv
module xps_checker #(
  parameter int NREG = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NREG-1:0] cs_o,
  input logic            ale_o,
  input logic            rd_o,
  input logic            wr_o,
  input logic            addr_drv_o,
  input logic            done_o,
  input logic            snap_en,
  input logic            accept,
  input logic            leave
);
  assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_o));

  assert_no_cs_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_o != '0) |-> snap_en);

  assert_ale_alone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |-> (!rd_o && !wr_o && cs_o != '0));

  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_o && wr_o));

  assert_drv_in_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_drv_o |-> (cs_o != '0 && !rd_o && !wr_o));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cs_o == '0 && !accept && !leave));
endmodule

bind xps_top xps_checker #(.NREG(NREG)) u_xps_chk (
  .clk(clk), .rst_n(rst_n), .cs_o(cs_o), .ale_o(ale_o), .rd_o(rd_o),
  .wr_o(wr_o), .addr_drv_o(addr_drv_o), .done_o(done_o),
  .snap_en(snap_en), .accept(accept), .leave(leave)
);

// File: tb/xps_top_test.sv
module xps_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 4;

  typedef struct packed {
    logic [3:0] csm;
    int cs_n; int ale_n; int rd_n; int wr_n; int drv_n;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_region = '0;
  logic rdy_pol = 1'b0, rdy_pin = 1'b1;
  logic [14:0] tcfg [NREG];
  logic [3:0]  fcfg [NREG];
  logic [NREG*15-1:0] tflat;
  logic [NREG*4-1:0]  fflat;
  logic ale, rd, wr, drv, done;
  logic [NREG-1:0] cs;

  int n_checks = 0, n_errors = 0, done_cnt = 0, issued = 0;
  int c_cs = 0, c_ale = 0, c_rd = 0, c_wr = 0, c_drv = 0;
  logic [3:0] seen = '0;
  exp_t  exp_q [$];
  string tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      tflat[i*15 +: 15] = tcfg[i];
      fflat[i*4 +: 4]   = fcfg[i];
    end
  end

  xps_top #(.NREG(NREG)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_region_i(req_region), .timing_cfg_i(tflat), .func_cfg_i(fflat),
    .ready_pol_i(rdy_pol), .ready_pin_i(rdy_pin), .ale_o(ale), .rd_o(rd),
    .wr_o(wr), .cs_o(cs), .addr_drv_o(drv), .done_o(done)
  );

  task automatic check(bit ok, string tag, string what, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // timing word: {Fwr[1:0], Frd[1:0], D, C[1:0], B, A[1:0], E[4:0]}
  function automatic logic [14:0] mk_tw(int a, int b, int c, int d, int e, int frd, int fwr);
    return {fwr[1:0], frd[1:0], d[0], c[1:0], b[0], a[1:0], e[4:0]};
  endfunction

  // monitor: accumulates per-access counts, compares on done
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10", "unexpected done", 1, 0);
        end else begin
          exp_t e; string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          check(c_cs  == e.cs_n,  t, "chip-select cycles", c_cs, e.cs_n);
          check(seen  == e.csm,   t, "chip-select mask", int'(seen), int'(e.csm));
          check(c_ale == e.ale_n, t, "ALE cycles", c_ale, e.ale_n);
          check(c_rd  == e.rd_n,  t, "read strobe cycles", c_rd, e.rd_n);
          check(c_wr  == e.wr_n,  t, "write strobe cycles", c_wr, e.wr_n);
          check(c_drv == e.drv_n, t, "address drive cycles", c_drv, e.drv_n);
        end
        c_cs = 0; c_ale = 0; c_rd = 0; c_wr = 0; c_drv = 0; seen = '0;
        done_cnt++;
      end else begin
        if (cs != '0) c_cs++;
        seen = seen | cs;
        if (ale) c_ale++;
        if (rd)  c_rd++;
        if (wr)  c_wr++;
        if (drv) c_drv++;
      end
    end
  end

  // driver: dly >= 0 asserts READY dly cycles after acceptance; dly < 0 leaves the pin as is
  task automatic access(int r, bit w, int dly, bit poke, string tag);
    exp_t e;
    int a, b, c, d, el, f, s, ex, redge, start;
    a  = int'(tcfg[r][6:5]);  b = int'(tcfg[r][7]) + 1;
    c  = int'(tcfg[r][9:8]);  d = int'(tcfg[r][10]);
    el = int'(tcfg[r][4:0]) + 1;
    f  = w ? int'(tcfg[r][14:13]) : int'(tcfg[r][12:11]);
    s  = a + b + c + d;
    ex = s + el;
    if (fcfg[r][1]) begin
      redge = (dly < 0) ? 0 : (fcfg[r][2] ? dly + 1 : dly + 3);
      if (redge > ex) ex = redge;
    end
    if (fcfg[r][0]) begin
      e.csm = 4'b1 << r; e.cs_n = ex + f; e.ale_n = b;
      e.rd_n = w ? 0 : ex - s; e.wr_n = w ? ex - s : 0;
      e.drv_n = fcfg[r][3] ? a + b : 0;
    end else begin
      e = '0;
    end
    exp_q.push_back(e); tag_q.push_back(tag); issued++;
    start = done_cnt;
    @(negedge clk); req_valid = 1'b1; req_region = 2'(r); req_write = w;
    @(negedge clk); req_valid = 1'b0;
    if (poke) begin
      @(negedge clk); req_valid = 1'b1; req_region = 2'd2; req_write = 1'b0;
      @(negedge clk); req_valid = 1'b0;
    end
    if (dly >= 0) begin
      repeat (dly) @(negedge clk);
      rdy_pin = rdy_pol;
    end
    while (done_cnt == start) @(negedge clk);
    rdy_pin = ~rdy_pol;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_up();
  end

  initial begin
    tcfg[0] = mk_tw(2, 1, 1, 1, 3, 2, 1); fcfg[0] = 4'b1001; // mux, no wait
    tcfg[1] = mk_tw(0, 0, 0, 0, 0, 0, 0); fcfg[1] = 4'b0001; // demux, minimal
    tcfg[2] = mk_tw(1, 1, 1, 1, 1, 1, 1); fcfg[2] = 4'b1000; // disabled
    tcfg[3] = mk_tw(0, 0, 0, 0, 0, 0, 0); fcfg[3] = 4'b0011; // wait, async
    repeat (3) @(negedge clk);
    // R1: quiet outputs after reset
    check(cs == '0 && !ale && !rd && !wr && !drv && !done, "R1", "outputs in reset",
          int'({cs, ale, rd, wr, drv, done}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cs == '0 && !done, "R1", "outputs after reset", int'({cs, done}), 0);

    access(0, 1'b0, -1, 1'b0, "R2/R3/R5/R6 read");
    access(0, 1'b1, -1, 1'b0, "R4/R5 write");
    access(1, 1'b1, -1, 1'b0, "R11 write");
    access(1, 1'b0, -1, 1'b0, "R11 read");
    access(2, 1'b0, -1, 1'b0, "R9 disabled");
    access(3, 1'b0, 5, 1'b0, "R7/R8 async");
    fcfg[3] = 4'b0111;
    access(3, 1'b0, 5, 1'b0, "R8 sync");
    // R7 active-high polarity
    rdy_pol = 1'b1; rdy_pin = 1'b0; repeat (4) @(negedge clk);
    access(3, 1'b1, 3, 1'b0, "R7 active high");
    // R7 READY already asserted: minimum length only
    tcfg[3] = mk_tw(0, 1, 0, 0, 3, 0, 2); fcfg[3] = 4'b0011;
    rdy_pin = 1'b1; repeat (4) @(negedge clk);
    access(3, 1'b1, -1, 1'b0, "R7 ready early");
    rdy_pol = 1'b0; rdy_pin = 1'b1; repeat (4) @(negedge clk);
    // R10: request while busy is ignored
    access(0, 1'b0, -1, 1'b1, "R10 busy");
    repeat (20) @(negedge clk);
    check(done_cnt == issued, "R10", "done pulses", done_cnt, issued);
    check(exp_q.size() == 0, "R10", "pending accesses", exp_q.size(), 0);
    finish_up();
  end
endmodule